// File: doc/BRIEF.md
# Embedded Flash Command Controller

This block sits between a small byte-wide register port and an on-chip NOR flash array that is modelled as a behavioural memory. Software places a 16-bit offset and a data byte in registers, then writes a command code. The controller carries out the command: it fills or clears a 128-byte page latch, erases a page or the whole array, folds the latch into an array page, or fetches a byte from the array or from a separate trim region into a read-back register.

Programming follows a fixed software sequence. The latch is first cleared, then loaded one byte per command at the offsets of interest, and then committed to the array page that holds the current offset. The commit ANDs each latch byte into the array, so programming can only clear bits. Erase returns bytes to 0xFF. Software polls the ready bit of the status register before it issues each command. Commands written while the controller is busy are dropped.

Top module: `eflash_ctrl`

## Requirements
- R1: After reset the status register (address 5) reads 0x80 (bit 7 = ready, bits 6:0 = 0). Offset high (address 0), offset low (address 1), data-in (address 2) and data-out (address 3) read 0x00.
- R2: Offset high, offset low and data-in are read/write registers at addresses 0, 1 and 2. The command register is at address 4. A write to address 4 launches a command, and address 4 reads back the last code written.
- R3: Command 0x60 sets every array byte to 0xFF.
- R4: Command 0x80 sets all latch bytes to 0xFF. Command 0x02 stores data-in at latch position offset mod 128. Command 0x70 writes array[p+i] = array[p+i] AND latch[i] for the 128-byte page p that holds the offset.
- R5: Programming can only clear bits. Committing a second latch image into an already programmed byte leaves the AND of both values.
- R6: Command 0x20 sets the 128 bytes of the page that holds the offset to 0xFF. Other pages are left untouched.
- R7: Command 0x90 loads data-out with the trim byte at index i = offset mod 512, where trim(i) = ((i[7:0]*29 + 0x5A) mod 256) XOR (i >> 8).
- R8: The ready bit reads 0 while a command runs, for exactly this many cycles: latch clear 128, page erase 128+ERASE_CYC, chip erase ARRAY_BYTES+CHIP_CYC, commit 256+PROG_CYC, array read 1. The defaults are ERASE_CYC=40, CHIP_CYC=60, PROG_CYC=30 and ARRAY_BYTES=1024. Latch load and trim read keep the ready bit at 1.
- R9: A command written while ready is 0 is ignored. It alters neither the array nor data-out.
- R10: A command code that is not one of 0x02, 0x03, 0x20, 0x60, 0x70, 0x80 or 0x90 has no effect, and the ready bit stays 1.
- R11: Command 0x03 loads data-out with the array byte at offset mod ARRAY_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Registered read data, valid the cycle after reg_rd |

## Verification
Programming is tried with several latch images: single bytes on a freshly erased page, a partly loaded latch whose untouched 0xFF positions must leave the array alone, and a second commit over already programmed data, which separates a true AND from a plain overwrite. Erase is tried per page next to a programmed neighbour page, to separate page scope from chip scope. Trim reads use offsets below, at and above the trim region size, which exposes index wrapping. Exact busy lengths per command, back-to-back command writes during an erase, and an unknown code show the ready-bit timing and which commands are dropped.

// File: rtl/eflash_pkg.sv
package eflash_pkg;

  localparam logic [2:0] RA_OFF_HI = 3'd0;
  localparam logic [2:0] RA_OFF_LO = 3'd1;
  localparam logic [2:0] RA_DIN    = 3'd2;
  localparam logic [2:0] RA_DOUT   = 3'd3;
  localparam logic [2:0] RA_CMD    = 3'd4;
  localparam logic [2:0] RA_STAT   = 3'd5;

  localparam logic [7:0] C_LOAD      = 8'h02;
  localparam logic [7:0] C_READ      = 8'h03;
  localparam logic [7:0] C_ERASE_PG  = 8'h20;
  localparam logic [7:0] C_ERASE_ALL = 8'h60;
  localparam logic [7:0] C_COMMIT    = 8'h70;
  localparam logic [7:0] C_CLEAR     = 8'h80;
  localparam logic [7:0] C_TRIM      = 8'h90;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_WAIT, S_RD} seq_st_e;
  typedef enum logic [2:0] {OP_NONE, OP_CLEAR, OP_ERASE_PG, OP_ERASE_ALL, OP_PROG, OP_READ} seq_op_e;

  // Trim region content, computed rather than stored
  function automatic logic [7:0] trim_byte(input logic [15:0] i);
    logic [7:0] prod;
    prod = i[7:0] * 8'd29;
    return (prod + 8'h5A) ^ i[15:8];
  endfunction

endpackage

// File: rtl/eflash_mem.sv
module eflash_mem #(
  parameter int DEPTH   = 128,
  parameter bit SYNC_RD = 1'b1,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (SYNC_RD) begin : g_sync
      always_ff @(posedge clk) rdata <= mem[raddr];
    end else begin : g_async
      assign rdata = mem[raddr];
    end
  endgenerate

endmodule

// File: rtl/eflash_regs.sv
module eflash_regs
  import eflash_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_rd,
  output logic [7:0]  reg_rdata,
  input  logic        ready,
  input  logic        dout_we,
  input  logic [7:0]  dout_d,
  output logic [15:0] offset,
  output logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        cmd_go,
  output logic [7:0]  cmd_code
);

  logic [7:0] off_hi, off_lo, din_q, dout_q, cmd_q;

  assign offset   = {off_hi, off_lo};
  assign din      = din_q;
  assign dout     = dout_q;
  assign cmd_go   = reg_wr && (reg_addr == RA_CMD);
  assign cmd_code = reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_hi <= '0;
      off_lo <= '0;
      din_q  <= '0;
      cmd_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_OFF_HI: off_hi <= reg_wdata;
        RA_OFF_LO: off_lo <= reg_wdata;
        RA_DIN:    din_q  <= reg_wdata;
        RA_CMD:    cmd_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          dout_q <= '0;
    else if (dout_we) dout_q <= dout_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_OFF_HI: reg_rdata <= off_hi;
        RA_OFF_LO: reg_rdata <= off_lo;
        RA_DIN:    reg_rdata <= din_q;
        RA_DOUT:   reg_rdata <= dout_q;
        RA_CMD:    reg_rdata <= cmd_q;
        RA_STAT:   reg_rdata <= {ready, 7'b0};
        default:   reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/eflash_seq.sv
module eflash_seq
  import eflash_pkg::*;
#(
  parameter int ARRAY_BYTES = 1024,
  parameter int PAGE_BYTES  = 128,
  parameter int TRIM_BYTES  = 512,
  parameter int ERASE_CYC   = 40,
  parameter int CHIP_CYC    = 60,
  parameter int PROG_CYC    = 30,
  localparam int AW = $clog2(ARRAY_BYTES),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int TW = $clog2(TRIM_BYTES),
  localparam int DW = $clog2(ERASE_CYC + CHIP_CYC + PROG_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_go,
  input  logic [7:0]    cmd_code,
  input  logic [15:0]   offset,
  input  logic [7:0]    din,
  output logic          ready,
  output logic          dout_we,
  output logic [7:0]    dout_d,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [7:0]    arr_wdata,
  output logic [AW-1:0] arr_raddr,
  input  logic [7:0]    arr_rdata,
  output logic          lat_we,
  output logic [PW-1:0] lat_waddr,
  output logic [7:0]    lat_wdata,
  output logic [PW-1:0] lat_raddr,
  input  logic [7:0]    lat_rdata
);

  seq_st_e       st;
  seq_op_e       op;
  logic [AW-1:0] idx;
  logic [AW:0]   left;
  logic          ph;
  logic [DW-1:0] wcnt;

  logic [AW-1:0] off_idx, page_base;
  logic [15:0]   trim_idx;
  logic          idle_go, step;

  assign off_idx   = offset[AW-1:0];
  assign page_base = {off_idx[AW-1:PW], {PW{1'b0}}};
  assign trim_idx  = {{(16-TW){1'b0}}, offset[TW-1:0]};
  assign idle_go   = (st == S_IDLE) && cmd_go;
  // commit spends two cycles per byte: read, then write back
  assign step      = (op != OP_PROG) || ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      op   <= OP_NONE;
      idx  <= '0;
      left <= '0;
      ph   <= 1'b0;
      wcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_go) begin
          ph <= 1'b0;
          case (cmd_code)
            C_READ: begin
              st <= S_RD;
              op <= OP_READ;
            end
            C_CLEAR: begin
              st   <= S_WALK;
              op   <= OP_CLEAR;
              idx  <= page_base;
              left <= (AW+1)'(PAGE_BYTES - 1);
            end
            C_ERASE_PG: begin
              st   <= S_WALK;
              op   <= OP_ERASE_PG;
              idx  <= page_base;
              left <= (AW+1)'(PAGE_BYTES - 1);
            end
            C_ERASE_ALL: begin
              st   <= S_WALK;
              op   <= OP_ERASE_ALL;
              idx  <= '0;
              left <= (AW+1)'(ARRAY_BYTES - 1);
            end
            C_COMMIT: begin
              st   <= S_WALK;
              op   <= OP_PROG;
              idx  <= page_base;
              left <= (AW+1)'(PAGE_BYTES - 1);
            end
            default: ;
          endcase
        end
        S_WALK: begin
          if (step) begin
            ph <= 1'b0;
            if (left == '0) begin
              case (op)
                OP_ERASE_PG:  begin st <= S_WAIT; wcnt <= DW'(ERASE_CYC - 1); end
                OP_ERASE_ALL: begin st <= S_WAIT; wcnt <= DW'(CHIP_CYC - 1);  end
                OP_PROG:      begin st <= S_WAIT; wcnt <= DW'(PROG_CYC - 1);  end
                default:      st <= S_IDLE;
              endcase
            end else begin
              idx  <= idx + 1'b1;
              left <= left - 1'b1;
            end
          end else begin
            ph <= 1'b1;
          end
        end
        S_WAIT: begin
          if (wcnt == '0) st <= S_IDLE;
          else            wcnt <= wcnt - 1'b1;
        end
        S_RD: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready = (st == S_IDLE);

  // array port
  assign arr_raddr = (st == S_IDLE) ? off_idx : idx;
  assign arr_waddr = idx;
  assign arr_we    = (st == S_WALK) &&
                     ((op == OP_ERASE_PG) || (op == OP_ERASE_ALL) || ((op == OP_PROG) && ph));
  assign arr_wdata = (op == OP_PROG) ? (arr_rdata & lat_rdata) : 8'hFF;

  // page latch port
  assign lat_raddr = idx[PW-1:0];
  assign lat_we    = (idle_go && (cmd_code == C_LOAD)) || ((st == S_WALK) && (op == OP_CLEAR));
  assign lat_waddr = (st == S_IDLE) ? off_idx[PW-1:0] : idx[PW-1:0];
  assign lat_wdata = (st == S_IDLE) ? din : 8'hFF;

  // read-back register
  assign dout_we = (st == S_RD) || (idle_go && (cmd_code == C_TRIM));
  assign dout_d  = (st == S_RD) ? arr_rdata : trim_byte(trim_idx);

endmodule

// File: rtl/eflash_ctrl.sv
module eflash_ctrl #(
  parameter int ARRAY_BYTES = 1024,
  parameter int PAGE_BYTES  = 128,
  parameter int TRIM_BYTES  = 512,
  parameter int ERASE_CYC   = 40,
  parameter int CHIP_CYC    = 60,
  parameter int PROG_CYC    = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata
);

  localparam int AW = $clog2(ARRAY_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [15:0]   offset;
  logic [7:0]    din, dout, cmd_code, dout_d;
  logic          cmd_go, ready, dout_we;
  logic          arr_we, lat_we;
  logic [AW-1:0] arr_waddr, arr_raddr;
  logic [7:0]    arr_wdata, arr_rdata;
  logic [PW-1:0] lat_waddr, lat_raddr;
  logic [7:0]    lat_wdata, lat_rdata;

  eflash_regs u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .ready(ready), .dout_we(dout_we), .dout_d(dout_d),
    .offset(offset), .din(din), .dout(dout),
    .cmd_go(cmd_go), .cmd_code(cmd_code)
  );

  eflash_seq #(
    .ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES), .TRIM_BYTES(TRIM_BYTES),
    .ERASE_CYC(ERASE_CYC), .CHIP_CYC(CHIP_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst(rst),
    .cmd_go(cmd_go), .cmd_code(cmd_code), .offset(offset), .din(din),
    .ready(ready), .dout_we(dout_we), .dout_d(dout_d),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .lat_we(lat_we), .lat_waddr(lat_waddr), .lat_wdata(lat_wdata),
    .lat_raddr(lat_raddr), .lat_rdata(lat_rdata)
  );

  eflash_mem #(.DEPTH(ARRAY_BYTES), .SYNC_RD(1'b1)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  eflash_mem #(.DEPTH(PAGE_BYTES), .SYNC_RD(1'b0)) u_latch (
    .clk(clk), .we(lat_we), .waddr(lat_waddr), .wdata(lat_wdata),
    .raddr(lat_raddr), .rdata(lat_rdata)
  );

endmodule

// File: rtl/eflash_ctrl_chk.sv
module eflash_ctrl_chk #(
  parameter int ERASE_CYC = 40,
  parameter int CHIP_CYC  = 60,
  parameter int PROG_CYC  = 30
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       reg_rd,
  input logic [7:0] reg_rdata,
  input logic       ready,
  input logic       arr_we
);

  localparam int MIN_DLY = (ERASE_CYC < PROG_CYC) ?
                           ((ERASE_CYC < CHIP_CYC) ? ERASE_CYC : CHIP_CYC) :
                           ((PROG_CYC < CHIP_CYC) ? PROG_CYC : CHIP_CYC);

  logic        cmd_wr, known, slow;
  logic [7:0]  last_code;
  logic [15:0] busy_cnt;

  assign cmd_wr = reg_wr && (reg_addr == 3'd4);
  assign known  = (reg_wdata == 8'h02) || (reg_wdata == 8'h03) || (reg_wdata == 8'h20) ||
                  (reg_wdata == 8'h60) || (reg_wdata == 8'h70) || (reg_wdata == 8'h80) ||
                  (reg_wdata == 8'h90);
  assign slow   = (reg_wdata == 8'h03) || (reg_wdata == 8'h20) || (reg_wdata == 8'h60) ||
                  (reg_wdata == 8'h70) || (reg_wdata == 8'h80);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_code <= '0;
      busy_cnt  <= '0;
    end else begin
      if (cmd_wr && ready) last_code <= reg_wdata;
      if (ready) busy_cnt <= '0;
      else       busy_cnt <= busy_cnt + 1'b1;
    end
  end

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ready);

  // R1
  status_pad_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd && (reg_addr == 3'd5) |=> (reg_rdata[6:0] == 7'd0));

  // R8
  busy_on_launch_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && ready && slow |=> !ready);

  // R8
  min_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) && ((last_code == 8'h20) || (last_code == 8'h60) || (last_code == 8'h70))
    |-> (busy_cnt >= 16'(MIN_DLY)));

  // R10
  unknown_noop_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && ready && !known |=> ready);

  // R9
  array_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !ready);

endmodule

bind eflash_ctrl eflash_ctrl_chk #(
  .ERASE_CYC(ERASE_CYC), .CHIP_CYC(CHIP_CYC), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata), .ready(ready), .arr_we(arr_we)
);

// File: tb/sim_eflash_ctrl.sv
module sim_eflash_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  eflash_ctrl u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic wait_ready(output int busy);
    logic [7:0] s;
    busy = 0;
    for (int k = 0; k < 5000; k++) begin
      rd_reg(3'd5, s);
      if (s[7]) break;
      busy++;
    end
  endtask

  task automatic do_cmd(input logic [7:0] c, output int busy);
    wr_reg(3'd4, c);
    wait_ready(busy);
  endtask

  task automatic set_off(input int o);
    wr_reg(3'd0, 8'(o >> 8));
    wr_reg(3'd1, 8'(o));
  endtask

  task automatic rd_arr(input int o, output logic [7:0] v);
    int b;
    set_off(o);
    do_cmd(8'h03, b);
    rd_reg(3'd3, v);
  endtask

  task automatic load(input int o, input logic [7:0] d);
    int b;
    set_off(o);
    wr_reg(3'd2, d);
    do_cmd(8'h02, b);
  endtask

  function automatic int trim_exp(input int off);
    int i;
    i = off % 512;
    return (((i & 255) * 29 + 'h5A) & 255) ^ (i >> 8);
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(3'd5, v); check("R1 status", v, 'h80);
    rd_reg(3'd0, v); check("R1 off_hi", v, 0);
    rd_reg(3'd1, v); check("R1 off_lo", v, 0);
    rd_reg(3'd2, v); check("R1 din", v, 0);
    rd_reg(3'd3, v); check("R1 dout", v, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr_reg(3'd0, 8'h12); wr_reg(3'd1, 8'h34); wr_reg(3'd2, 8'h5A);
    rd_reg(3'd0, v); check("R2 off_hi", v, 'h12);
    rd_reg(3'd1, v); check("R2 off_lo", v, 'h34);
    rd_reg(3'd2, v); check("R2 din", v, 'h5A);
    wr_reg(3'd4, 8'hC4);
    rd_reg(3'd4, v); check("R2 cmd readback", v, 'hC4);
  endtask

  task automatic t_chip_erase();
    int b;
    logic [7:0] v;
    do_cmd(8'h60, b); check("R8 chip erase busy", b, 1024 + 60);
    rd_arr(0, v);    check("R3 byte 0", v, 'hFF);
    rd_arr(513, v);  check("R3 byte 513", v, 'hFF);
    rd_arr(1023, v); check("R3 byte 1023", v, 'hFF);
  endtask

  task automatic t_program();
    int b;
    logic [7:0] v;
    set_off(128);
    do_cmd(8'h80, b); check("R8 latch clear busy", b, 128);
    load(128, 8'hA5); load(129, 8'h3C); load(130, 8'h00); load(131, 8'h7E);
    set_off(130);
    do_cmd(8'h70, b); check("R8 commit busy", b, 256 + 30);
    rd_arr(128, v); check("R4 byte 128", v, 'hA5);
    rd_arr(129, v); check("R4 byte 129", v, 'h3C);
    rd_arr(130, v); check("R4 byte 130", v, 'h00);
    rd_arr(131, v); check("R4 byte 131", v, 'h7E);
    rd_arr(132, v); check("R4 unloaded byte 132", v, 'hFF);
    rd_arr(127, v); check("R4 other page 127", v, 'hFF);
  endtask

  task automatic t_and();
    int b;
    logic [7:0] v;
    set_off(128); do_cmd(8'h80, b);
    load(128, 8'h0F);
    do_cmd(8'h70, b);
    rd_arr(128, v); check("R5 and 0xA5&0x0F", v, 'h05);
    rd_arr(129, v); check("R5 untouched 129", v, 'h3C);
  endtask

  task automatic t_page_erase();
    int b;
    logic [7:0] v;
    set_off(0); do_cmd(8'h80, b);
    load(5, 8'h11);
    do_cmd(8'h70, b);
    set_off(200);
    do_cmd(8'h20, b); check("R8 page erase busy", b, 128 + 40);
    rd_arr(128, v); check("R6 erased 128", v, 'hFF);
    rd_arr(131, v); check("R6 erased 131", v, 'hFF);
    rd_arr(5, v);   check("R6 neighbour page kept", v, 'h11);
  endtask

  task automatic t_trim();
    int b;
    logic [7:0] v;
    int offs[3] = '{'h0003, 'h01FF, 'h0245};
    foreach (offs[k]) begin
      set_off(offs[k]);
      do_cmd(8'h90, b);
      check("R8 trim keeps ready", b, 0);
      rd_reg(3'd3, v); check("R7 trim byte", v, trim_exp(offs[k]));
    end
  endtask

  task automatic t_busy_ignore();
    int b;
    logic [7:0] v, d0;
    rd_arr(5, d0);
    set_off('h300);
    wr_reg(3'd4, 8'h20);
    wr_reg(3'd4, 8'h60);
    wr_reg(3'd4, 8'h90);
    wait_ready(b);
    rd_reg(3'd3, v); check("R9 dout unchanged", v, d0);
    rd_arr(5, v);    check("R9 chip erase dropped", v, 'h11);
    rd_arr('h300, v); check("R9 page erase done", v, 'hFF);
  endtask

  task automatic t_unknown();
    logic [7:0] v;
    wr_reg(3'd4, 8'h55);
    rd_reg(3'd5, v); check("R10 ready stays 1", v, 'h80);
    rd_reg(3'd3, v); check("R10 dout unchanged", v, 'hFF);
    rd_arr(5, v);    check("R10 array unchanged / R11 read", v, 'h11);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_chip_erase();
    t_program();
    t_and();
    t_page_erase();
    t_trim();
    t_busy_ignore();
    t_unknown();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule